// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a serial playback audio stream into parallel samples. It runs directly on the external bit clock. It watches a left/right (or frame-sync) clock and up to three serial data lines, and it supports five framing formats. Three of them are stereo formats, in which each data line carries one left/right pair. The other two are time-division formats, in which six channels are packed back to back on data line 0 behind a frame-sync rising edge.

Each completed word leaves the block as a single-cycle valid strobe. The strobe comes with the word left-aligned in a 32-bit bus and with a channel index from 0 to 5. In the stereo formats, the three words that complete together leave on consecutive cycles, lane 0 first. The format code and the word-length code are static configuration. They must only change while reset is held. Any illegal combination is flagged and receives nothing.

Top module: `msa_rx`

## Requirements
- R1: `cfg_err` is high whenever `fmt` is 5, 6 or 7, or `fmt`=1 (right-justified) with `wlen`=3 (32 bits); while it is high `smp_valid` never rises; for every other setting `cfg_err` is low.
- R2: With `fmt`=0 (left-justified), the MSB is the bit sampled on the first rising `clk` edge at which `lrc` shows its new level; a word sampled while `lrc` is 1 is a left word, while 0 a right word.
- R3: With `fmt`=2 (I2S), the MSB is the bit sampled one `clk` edge after the edge at which `lrc` shows its new level; a word whose phase has `lrc` at 0 is a left word.
- R4: With `fmt`=1 (right-justified), the word is the N bits sampled on the N edges just before the edge at which `lrc` shows a new level; it is left if `lrc` was 1 during them; no word is produced at the first `lrc` change after reset.
- R5: With `fmt`=3 (DSP-early), the MSB of slot 0 is sampled on the edge at which a rising `lrc` is first seen; six words follow back to back on `din[0]`, reported as channels 0 to 5.
- R6: With `fmt`=4 (DSP-late), the same as R5 but with the slot-0 MSB sampled one edge later; a frame of exactly 6×N edges is received completely.
- R7: Word length N is set by `wlen` (0=16, 1=20, 2=24, 3=32 bits), MSB first; `smp_data` holds the word with its MSB at bit 31 and zeros below the LSB.
- R8: In the stereo formats, the words of lanes 0, 1 and 2 carry channels 2·lane+side (side 0=left, 1=right). They appear with `smp_valid` high on three consecutive cycles. The first of these cycles directly follows the edge that sampled the word's last bit (for R4, the edge that saw `lrc` change).
- R9: Bits sampled after the N-th bit of a phase, or after slot 5 of a frame, produce no word and do not change later words.
- R10: While `rst_n` is low, `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| fmt | input | 3 | Framing code: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP-early, 4 DSP-late |
| wlen | input | 2 | Word-length code: 0=16, 1=20, 2=24, 3=32 bits |
| lrc | input | 1 | Left/right clock, or frame sync in the DSP formats |
| din | input | 3 | Serial data lines; only line 0 is used in the DSP formats |
| cfg_err | output | 1 | Illegal configuration flag |
| smp_valid | output | 1 | One-cycle strobe per received word |
| smp_data | output | 32 | Received word, MSB at bit 31 |
| smp_chan | output | 3 | Channel index 0 to 5 of the word |

## Verification
A wrong bit counter or slot counter shows up as a shifted word on `smp_data`, or as a strobe one edge early or late. Either fault is visible at the first word after the fault. A wrong side or slot register gives a wrong `smp_chan` on that same word. A faulty pending-lane store breaks the three-cycle burst within two cycles of the first word. A broken arming or frame-sync detector changes how many words a run produces. For that reason the bench compares every cycle against a behavioural model and also counts the words of each run against a count derived from the format.

// File: rtl/msa_rx_pkg.sv
package msa_rx_pkg;

  localparam logic [2:0] FMT_LJ   = 3'd0;
  localparam logic [2:0] FMT_RJ   = 3'd1;
  localparam logic [2:0] FMT_I2S  = 3'd2;
  localparam logic [2:0] FMT_DSPE = 3'd3;
  localparam logic [2:0] FMT_DSPL = 3'd4;

  localparam logic [1:0] WL_32 = 2'd3;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    wlen_bits = 6'd16;
      2'd1:    wlen_bits = 6'd20;
      2'd2:    wlen_bits = 6'd24;
      default: wlen_bits = 6'd32;
    endcase
  endfunction

  function automatic logic cfg_illegal(input logic [2:0] f, input logic [1:0] w);
    cfg_illegal = (f > FMT_DSPL) || ((f == FMT_RJ) && (w == WL_32));
  endfunction

endpackage

// File: rtl/msa_rx_frame.sv
module msa_rx_frame
  import msa_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] fmt,
  input  logic       lrc,
  output logic       first,
  output logic       first_left,
  output logic       rj_cap,
  output logic       rj_left
);

  logic lrc_q, lrc_n;
  logic dly_q, dly_n;
  logic dside_q, dside_n;
  logic armed_q, armed_n;
  logic trans, rise, is_dsp, delayed, evt;

  always_comb begin
    trans      = lrc ^ lrc_q;
    rise       = lrc & ~lrc_q;
    is_dsp     = (fmt == FMT_DSPE) || (fmt == FMT_DSPL);
    delayed    = (fmt == FMT_I2S) || (fmt == FMT_DSPL);
    evt        = en & (fmt != FMT_RJ) & (is_dsp ? rise : trans);
    // one-bit-delayed formats start on the edge after the event
    first      = delayed ? (dly_q & en) : evt;
    first_left = delayed ? dside_q : lrc;
    rj_cap     = en & (fmt == FMT_RJ) & trans & armed_q;
    rj_left    = lrc_q;
    lrc_n      = lrc;
    dly_n      = evt;
    dside_n    = ~lrc;
    armed_n    = armed_q | trans;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrc_q   <= 1'b0;
      dly_q   <= 1'b0;
      dside_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      lrc_q   <= lrc_n;
      dly_q   <= dly_n;
      dside_q <= dside_n;
      armed_q <= armed_n;
    end
  end

endmodule

// File: rtl/msa_rx_seq.sv
module msa_rx_seq #(
  parameter int SLOTS = 6,
  parameter int SW    = 3,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first,
  input  logic          first_left,
  input  logic          is_dsp,
  input  logic [CW-1:0] nbits,
  output logic          done,
  output logic [SW-1:0] done_slot,
  output logic          done_left
);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [SW-1:0] slot_q, slot_n;
  logic          left_q, left_n;
  logic          run;
  logic [CW-1:0] cur;
  logic [SW-1:0] slot_c;

  always_comb begin
    run       = first | act_q;
    cur       = first ? CW'(1) : cnt_q + 1'b1;
    slot_c    = first ? '0 : slot_q;
    done      = run && (cur == nbits);
    done_slot = slot_c;
    done_left = first ? first_left : left_q;
    act_n     = act_q;
    cnt_n     = cnt_q;
    slot_n    = slot_q;
    left_n    = done_left;
    if (run) begin
      if (done) begin
        cnt_n = '0;
        if (is_dsp && (slot_c != SW'(SLOTS - 1))) begin
          act_n  = 1'b1;
          slot_n = slot_c + 1'b1;
        end else begin
          act_n  = 1'b0;
          slot_n = '0;
        end
      end else begin
        act_n  = 1'b1;
        cnt_n  = cur;
        slot_n = slot_c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      left_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      slot_q <= slot_n;
      left_q <= left_n;
    end
  end

endmodule

// File: rtl/msa_rx_lane.sv
module msa_rx_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] sh_q,
  output logic [W-1:0] sh_n
);

  always_comb sh_n = {sh_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

endmodule

// File: rtl/msa_rx_emit.sv
module msa_rx_emit #(
  parameter int W     = 32,
  parameter int LANES = 3,
  parameter int SW    = 3,
  parameter int CHW   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      word_done,
  input  logic                      rj_cap,
  input  logic [SW-1:0]             done_slot,
  input  logic                      done_left,
  input  logic                      rj_left,
  input  logic                      is_dsp,
  input  logic [5:0]                nbits,
  input  logic [LANES-1:0][W-1:0]   sh_q,
  input  logic [LANES-1:0][W-1:0]   sh_n,
  output logic                      smp_valid,
  output logic [W-1:0]              smp_data,
  output logic [CHW-1:0]            smp_chan
);

  localparam int PW = $clog2(LANES + 1);

  logic [LANES-1:0][W-1:0]   al;
  logic [LANES-2:0][W-1:0]   hd_q, hd_n;
  logic [LANES-2:0][CHW-1:0] hc_q, hc_n;
  logic [PW-1:0]             pend_q, pend_n;
  logic                      v_q, v_n;
  logic [W-1:0]              d_q, d_n;
  logic [CHW-1:0]            c_q, c_n;
  logic [5:0]                shamt;
  logic                      fresh, side;

  always_comb begin
    shamt = 6'(W) - nbits;
    fresh = word_done | rj_cap;
    side  = rj_cap ? ~rj_left : ~done_left;
    for (int l = 0; l < LANES; l++)
      al[l] = (rj_cap ? sh_q[l] : sh_n[l]) << shamt;
    hd_n   = hd_q;
    hc_n   = hc_q;
    pend_n = pend_q;
    d_n    = d_q;
    c_n    = c_q;
    v_n    = 1'b0;
    if (fresh) begin
      v_n = 1'b1;
      d_n = al[0];
      c_n = is_dsp ? CHW'(done_slot) : CHW'(side);
      for (int l = 1; l < LANES; l++) begin
        hd_n[l-1] = al[l];
        hc_n[l-1] = CHW'(2 * l) | CHW'(side);
      end
      pend_n = is_dsp ? '0 : PW'(LANES - 1);
    end else if (pend_q != '0) begin
      v_n = 1'b1;
      d_n = hd_q[0];
      c_n = hc_q[0];
      for (int l = 0; l < LANES - 2; l++) begin
        hd_n[l] = hd_q[l+1];
        hc_n[l] = hc_q[l+1];
      end
      pend_n = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q   <= '0;
      hc_q   <= '0;
      pend_q <= '0;
      v_q    <= 1'b0;
      d_q    <= '0;
      c_q    <= '0;
    end else begin
      hd_q   <= hd_n;
      hc_q   <= hc_n;
      pend_q <= pend_n;
      v_q    <= v_n;
      d_q    <= d_n;
      c_q    <= c_n;
    end
  end

  assign smp_valid = v_q;
  assign smp_data  = d_q;
  assign smp_chan  = c_q;

endmodule

// File: rtl/msa_rx.sv
module msa_rx
  import msa_rx_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 3,
  parameter int SLOTS = 6,
  parameter int CHW   = (2 * LANES > SLOTS) ? $clog2(2 * LANES) : $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt,
  input  logic [1:0]       wlen,
  input  logic             lrc,
  input  logic [LANES-1:0] din,
  output logic             cfg_err,
  output logic             smp_valid,
  output logic [W-1:0]     smp_data,
  output logic [CHW-1:0]   smp_chan
);

  localparam int SW = $clog2(SLOTS);

  logic                    en, is_dsp;
  logic [5:0]              nbits;
  logic                    first, first_left, rj_cap, rj_left;
  logic                    done, done_left;
  logic [SW-1:0]           done_slot;
  logic [LANES-1:0][W-1:0] sh_q, sh_n;

  always_comb begin
    cfg_err = cfg_illegal(fmt, wlen);
    en      = ~cfg_err;
    is_dsp  = (fmt == FMT_DSPE) || (fmt == FMT_DSPL);
    nbits   = wlen_bits(wlen);
  end

  msa_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .lrc(lrc),
    .first(first), .first_left(first_left), .rj_cap(rj_cap), .rj_left(rj_left)
  );

  msa_rx_seq #(.SLOTS(SLOTS), .SW(SW), .CW(6)) u_seq (
    .clk(clk), .rst_n(rst_n), .first(first), .first_left(first_left),
    .is_dsp(is_dsp), .nbits(nbits),
    .done(done), .done_slot(done_slot), .done_left(done_left)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] q_w, n_w;
    msa_rx_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(din[g]), .sh_q(q_w), .sh_n(n_w)
    );
    assign sh_q[g] = q_w;
    assign sh_n[g] = n_w;
  end

  msa_rx_emit #(.W(W), .LANES(LANES), .SW(SW), .CHW(CHW)) u_emit (
    .clk(clk), .rst_n(rst_n), .word_done(done & en), .rj_cap(rj_cap),
    .done_slot(done_slot), .done_left(done_left), .rj_left(rj_left),
    .is_dsp(is_dsp), .nbits(nbits), .sh_q(sh_q), .sh_n(sh_n),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
  );

endmodule

// File: rtl/msa_rx_chk.sv
module msa_rx_chk #(
  parameter int W   = 32,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     fmt,
  input logic [1:0]     wlen,
  input logic           cfg_err,
  input logic           smp_valid,
  input logic [W-1:0]   smp_data,
  input logic [CHW-1:0] smp_chan
);

  // R1: a refused configuration yields no words
  a_r1_refused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !smp_valid);

  // R8: channel index stays within the six channels
  a_r8_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_chan < CHW'(6)));

  // R8: lanes 1 and 2 always follow a strobe of the previous cycle
  a_r8_lane_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (fmt < 3'd3) && (smp_chan >= CHW'(2))) |-> $past(smp_valid));

  // R7: 16-bit words leave the low half zero
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (wlen == 2'd0)) |-> (smp_data[15:0] == 16'd0));

  // R10: no strobe during reset
  always @(posedge clk) begin
    if (!rst_n) a_r10_reset_quiet: assert (!smp_valid);
  end

endmodule

bind msa_rx msa_rx_chk #(.W(W), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .cfg_err(cfg_err),
  .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
);

// File: tb/msa_rx_test.sv
module msa_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  wlen = 2'd0;
  logic        lrc = 1'b0;
  logic [2:0]  din = 3'd0;
  logic        cfg_err;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic [2:0]  smp_chan;

  int    errors = 0;
  int    checks = 0;
  int    seen = 0;
  bit    running = 0;
  bit    finished = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  msa_rx uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen), .lrc(lrc), .din(din),
    .cfg_err(cfg_err), .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_hist [3][$];
  bit          m_col  [3][$];
  logic [31:0] q_d [$];
  int          q_c [$];
  int          m_lrcp, m_dpend, m_dside, m_armed, m_act, m_slot, m_side;
  bit          exp_v;
  logic [31:0] exp_d;
  int          exp_c;

  function automatic int nb_of(input logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic model_step();
    int  nb   = nb_of(wlen);
    int  l    = int'(lrc);
    bit  tr   = (l != m_lrcp);
    bit  ri   = (l == 1) && (m_lrcp == 0);
    bit  err  = (fmt > 3'd4) || (fmt == 3'd1 && wlen == 2'd3);
    bit  dsp  = (fmt >= 3'd3);
    bit  dly  = (fmt == 3'd2) || (fmt == 3'd4);
    bit  evt, bnow, snow;
    logic [31:0] w;
    if (!err && fmt == 3'd1) begin
      if (tr && m_armed != 0)
        for (int ln = 0; ln < 3; ln++) begin
          w = '0;
          for (int i = 0; i < nb; i++) w[31-i] = m_hist[ln][m_hist[ln].size() - nb + i];
          q_d.push_back(w);
          q_c.push_back(2 * ln + ((m_lrcp == 1) ? 0 : 1));
        end
      if (tr) m_armed = 1;
    end else if (!err) begin
      evt  = dsp ? ri : tr;
      bnow = dly ? (m_dpend != 0) : evt;
      snow = dly ? (m_dside != 0) : (l == 1);
      m_dpend = int'(evt);
      m_dside = int'(l == 0);
      if (bnow) begin
        m_act = 1; m_slot = 0; m_side = int'(snow);
        for (int ln = 0; ln < 3; ln++) m_col[ln].delete();
      end
      if (m_act != 0) begin
        for (int ln = 0; ln < 3; ln++) m_col[ln].push_back(din[ln]);
        if (m_col[0].size() == nb) begin
          for (int ln = 0; ln < (dsp ? 1 : 3); ln++) begin
            w = '0;
            for (int i = 0; i < nb; i++) w[31-i] = m_col[ln][i];
            q_d.push_back(w);
            q_c.push_back(dsp ? m_slot : 2 * ln + ((m_side != 0) ? 0 : 1));
          end
          for (int ln = 0; ln < 3; ln++) m_col[ln].delete();
          if (dsp) begin
            m_slot++;
            if (m_slot == 6) m_act = 0;
          end else m_act = 0;
        end
      end
    end
    for (int ln = 0; ln < 3; ln++) begin
      m_hist[ln].push_back(din[ln]);
      if (m_hist[ln].size() > 32) void'(m_hist[ln].pop_front());
    end
    m_lrcp = l;
    if (q_d.size() > 0) begin
      exp_v = 1; exp_d = q_d.pop_front(); exp_c = q_c.pop_front();
    end else exp_v = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lrcp = 0; m_dpend = 0; m_dside = 0; m_armed = 0;
      m_act = 0; m_slot = 0; m_side = 0;
      for (int ln = 0; ln < 3; ln++) begin
        m_hist[ln].delete();
        m_col[ln].delete();
        for (int i = 0; i < 32; i++) m_hist[ln].push_back(1'b0);
      end
      q_d.delete(); q_c.delete();
      exp_v = 0; exp_d = '0; exp_c = 0;
    end else model_step();
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && running) begin
      checks++;
      if (smp_valid !== exp_v) begin
        errors++;
        $display("FAIL %s valid: got %0b expected %0b at %0t", cur_req, smp_valid, exp_v, $time);
      end
      if (exp_v) begin
        checks++;
        if (smp_data !== exp_d || smp_chan !== 3'(exp_c)) begin
          errors++;
          $display("FAIL %s word: got %h/ch%0d expected %h/ch%0d", cur_req,
                   smp_data, smp_chan, exp_d, exp_c);
        end
      end
      if (smp_valid) seen++;
    end
  end

  task automatic check1(input string req, input string what, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic do_reset();
    running = 0;
    rst_n = 1'b0; lrc = 1'b0; din = 3'd0;
    repeat (2) @(negedge clk);
    check1("R10", "valid in reset", int'(smp_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic [2:0] f, input logic [1:0] w, input int per,
                     input int hi, input int n, input int words, input int err_exp,
                     input string tag);
    fmt = f; wlen = w; cur_req = tag;
    do_reset();
    seen = 0; running = 1;
    check1("R1", "cfg_err", int'(cfg_err), err_exp);
    for (int i = 0; i < per * n; i++) begin
      @(negedge clk);
      lrc = ((i % per) < hi);
      din = 3'($urandom);
    end
    repeat (6) @(negedge clk);
    @(posedge clk);
    running = 0;
    check1(tag, "word count", seen, words);
  endtask

  initial begin
    // R2 R7 R8: left-justified, tight and padded phases (R9 extra bits)
    run(3'd0, 2'd0, 32, 16, 4, 24, 0, "R2 R7 R8");
    run(3'd0, 2'd1, 50, 27, 3, 18, 0, "R2 R9");
    // R3: I2S, exact and longer phases
    run(3'd2, 2'd2, 48, 24, 3, 18, 0, "R3 R8");
    run(3'd2, 2'd0, 40, 19, 3, 18, 0, "R3 R9");
    // R4: right-justified, first change only arms
    run(3'd1, 2'd1, 46, 23, 3, 15, 0, "R4 R9");
    run(3'd1, 2'd0, 32, 16, 4, 21, 0, "R4 R8");
    // R5: DSP-early, exact frame and long frame
    run(3'd3, 2'd0, 96, 3, 3, 18, 0, "R5 R7");
    run(3'd3, 2'd1, 130, 1, 2, 12, 0, "R5 R9");
    // R6: DSP-late, exact 6N frame and long frame
    run(3'd4, 2'd3, 192, 5, 2, 12, 0, "R6 R7");
    run(3'd4, 2'd2, 150, 2, 2, 12, 0, "R6 R9");
    // R1: refused configurations
    run(3'd1, 2'd3, 40, 20, 3, 0, 1, "R1");
    run(3'd6, 2'd0, 40, 20, 2, 0, 1, "R1");
    fmt = 3'd7; #1;
    check1("R1", "cfg_err fmt7", int'(cfg_err), 1);
    fmt = 3'd4; wlen = 2'd3; #1;
    check1("R1", "cfg_err dsp32", int'(cfg_err), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog %s: got hung run expected completion", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule